// File: doc/BRIEF.md
# Link Receiver Error Recovery Controller

This block is the receive-side link-level state machine of a serial packet port. It keeps the acknowledge ID it expects on the next packet. It watches decoded control symbols and the end-of-packet status and decides whether each packet is accepted. When a problem shows up, it asks the transmit side to send a control symbol to the link partner.

There are two separate stop states. A corrupted packet, a corrupted control symbol or an out-of-sequence acknowledge ID puts the receiver into error-stop. In that state it refuses packets and sends a packet-not-accepted symbol. It leaves error-stop only after a link-request arrives, and it answers that request with a link-response carrying the expected ID. A packet that arrives while no receive buffer is free puts the receiver into retry-stop and sends a packet-retry symbol. Only a restart-from-retry symbol from the partner ends retry-stop.

The stop levels and their one-cycle entry pulses drive the port status register. All outputs are registered and change one clock after the input that causes them.

Top module: `rx_link_recovery`

## Requirements
- R1: After reset, `err_stop`, `retry_stop`, `tx_req`, `pkt_accept` and both entry pulses are 0, and `next_ackid` is 0.
- R2: In the running state, a packet end with good CRC, `pkt_ackid` equal to `next_ackid` and `buf_free`=1 raises `pkt_accept` for one cycle on the next clock. `next_ackid` then increments modulo 32. `next_ackid` changes on no other event.
- R3: In the running state, any of three events enters error-stop on the next clock: a packet end with bad CRC, a packet end whose `pkt_ackid` differs from `next_ackid`, or a valid symbol with `sym_ok`=0. On that clock `err_enter` pulses for one cycle. A single `tx_req` is also issued with `tx_kind`=2'b00 (packet-not-accepted) and `tx_ackid` equal to `next_ackid`.
- R4: In error-stop, every packet is dropped: there is no `pkt_accept` and `next_ackid` does not change.
- R5: In error-stop, a valid symbol with `sym_ok`=1 and `sym_kind`=2'b01 (link-request) issues one `tx_req` with `tx_kind`=2'b10 (link-response) and `tx_ackid`=`next_ackid`. The state returns to running on the same clock. Corrupted link-requests do not end error-stop.
- R6: In the running state, a packet end that passes the checks in R3 while `buf_free`=0 is dropped and enters retry-stop on the next clock. On that clock `retry_enter` pulses for one cycle. A single `tx_req` is also issued with `tx_kind`=2'b01 (packet-retry) and `tx_ackid`=`next_ackid`.
- R7: In retry-stop, only a valid symbol with `sym_ok`=1 and `sym_kind`=2'b10 (restart-from-retry) returns to running, with no transmit request. Packets, link-requests and corrupted symbols are ignored there. After the return, packets are accepted again.
- R8: `err_stop` and `retry_stop` are never both 1. When an error condition and an empty buffer occur together, error-stop wins.
- R9: In the running state, link-request and restart-from-retry symbols produce no transmit request and no state change. In error-stop, restart-from-retry is ignored. Symbol kinds 2'b00 (idle) and 2'b11 (other) with `sym_ok`=1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_vld | input | 1 | Decoded control symbol present this cycle |
| sym_ok | input | 1 | Symbol passed its check |
| sym_kind | input | 2 | 00 idle, 01 link-request, 10 restart-from-retry, 11 other |
| pkt_end | input | 1 | Packet completed this cycle |
| pkt_crc_ok | input | 1 | Packet CRC good |
| pkt_ackid | input | AW | Acknowledge ID carried by the packet |
| buf_free | input | 1 | A receive buffer is available |
| tx_req | output | 1 | Request to send a control symbol |
| tx_kind | output | 2 | 00 packet-not-accepted, 01 packet-retry, 10 link-response |
| tx_ackid | output | AW | Acknowledge ID for the requested symbol |
| pkt_accept | output | 1 | Packet accepted |
| next_ackid | output | AW | Expected acknowledge ID |
| err_stop | output | 1 | Error-stop level |
| retry_stop | output | 1 | Retry-stop level |
| err_enter | output | 1 | One-cycle pulse on error-stop entry |
| retry_enter | output | 1 | One-cycle pulse on retry-stop entry |

## Verification
The assertions check several properties on every cycle:
- the two stop levels never overlap;
- no packet is accepted out of a stop state;
- the ID advances only by one and only on an accept;
- each stop entry comes with its pulse and the right request;
- each exit is caused by the correct symbol and produces the right reply.

Only the bench scenarios can show which input patterns cause which state. That covers mismatched IDs, corrupted idles, error-over-retry priority, the wrap from 31 to 0, and the symbols each state must ignore.

// File: rtl/rx_link_recovery.sv
module rx_link_recovery #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sym_vld,
  input  logic          sym_ok,
  input  logic [1:0]    sym_kind,
  input  logic          pkt_end,
  input  logic          pkt_crc_ok,
  input  logic [AW-1:0] pkt_ackid,
  input  logic          buf_free,
  output logic          tx_req,
  output logic [1:0]    tx_kind,
  output logic [AW-1:0] tx_ackid,
  output logic          pkt_accept,
  output logic [AW-1:0] next_ackid,
  output logic          err_stop,
  output logic          retry_stop,
  output logic          err_enter,
  output logic          retry_enter
);
  localparam logic [1:0] K_LREQ = 2'b01;
  localparam logic [1:0] K_RFR  = 2'b10;
  localparam logic [1:0] T_PNA  = 2'b00;
  localparam logic [1:0] T_PR   = 2'b01;
  localparam logic [1:0] T_LRSP = 2'b10;

  typedef enum logic [1:0] {ST_RUN, ST_ERR, ST_RTY} st_t;
  st_t st, st_n;

  wire sym_bad  = sym_vld & ~sym_ok;
  wire sym_lreq = sym_vld & sym_ok & (sym_kind == K_LREQ);
  wire sym_rfr  = sym_vld & sym_ok & (sym_kind == K_RFR);
  wire pkt_bad  = pkt_end & (~pkt_crc_ok | (pkt_ackid != next_ackid));
  wire run_err  = (st == ST_RUN) & (sym_bad | pkt_bad);
  wire run_rty  = (st == ST_RUN) & ~run_err & pkt_end & ~buf_free;
  wire run_ok   = (st == ST_RUN) & ~run_err & pkt_end & buf_free;
  wire err_exit = (st == ST_ERR) & sym_lreq;
  wire rty_exit = (st == ST_RTY) & sym_rfr;

  always_comb begin
    st_n = st;
    if (run_err)       st_n = ST_ERR;
    else if (run_rty)  st_n = ST_RTY;
    else if (err_exit || rty_exit) st_n = ST_RUN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_RUN;
      next_ackid  <= '0;
      tx_req      <= 1'b0;
      tx_kind     <= T_PNA;
      tx_ackid    <= '0;
      pkt_accept  <= 1'b0;
      err_enter   <= 1'b0;
      retry_enter <= 1'b0;
    end else begin
      st          <= st_n;
      pkt_accept  <= run_ok;
      err_enter   <= run_err;
      retry_enter <= run_rty;
      tx_req      <= run_err | run_rty | err_exit;
      if (run_ok) next_ackid <= next_ackid + 1'b1;
      if (run_err | run_rty | err_exit) begin
        tx_ackid <= next_ackid;
        tx_kind  <= run_err ? T_PNA : (run_rty ? T_PR : T_LRSP);
      end
    end
  end

  assign err_stop   = (st == ST_ERR);
  assign retry_stop = (st == ST_RTY);
endmodule

// File: rtl/rx_link_recovery_chk.sv
module rx_link_recovery_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sym_vld,
  input logic          sym_ok,
  input logic [1:0]    sym_kind,
  input logic          tx_req,
  input logic [1:0]    tx_kind,
  input logic [AW-1:0] tx_ackid,
  input logic          pkt_accept,
  input logic [AW-1:0] next_ackid,
  input logic          err_stop,
  input logic          retry_stop,
  input logic          err_enter,
  input logic          retry_enter
);
  assert_exclusive_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_stop && retry_stop));

  assert_no_accept_in_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_accept |-> (!$past(err_stop) && !$past(retry_stop)));

  assert_ackid_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_accept |-> next_ackid == AW'($past(next_ackid) + 1'b1));

  assert_ackid_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_accept |-> $stable(next_ackid));

  assert_err_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_stop) |-> (err_enter && tx_req && tx_kind == 2'b00 && tx_ackid == $past(next_ackid)));

  assert_retry_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(retry_stop) |-> (retry_enter && tx_req && tx_kind == 2'b01));

  assert_err_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_stop) |-> (tx_req && tx_kind == 2'b10 && $past(sym_vld && sym_ok && sym_kind == 2'b01)));

  assert_retry_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(retry_stop) |-> ($past(sym_vld && sym_ok && sym_kind == 2'b10) && !tx_req));
endmodule

bind rx_link_recovery rx_link_recovery_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sym_vld(sym_vld), .sym_ok(sym_ok), .sym_kind(sym_kind),
  .tx_req(tx_req), .tx_kind(tx_kind), .tx_ackid(tx_ackid), .pkt_accept(pkt_accept),
  .next_ackid(next_ackid), .err_stop(err_stop), .retry_stop(retry_stop),
  .err_enter(err_enter), .retry_enter(retry_enter)
);

// File: tb/sim_rx_link_recovery.sv
module sim_rx_link_recovery;
  logic clk = 0;
  logic rst_n = 0;
  logic sym_vld = 0, sym_ok = 0, pkt_end = 0, pkt_crc_ok = 0, buf_free = 1;
  logic [1:0] sym_kind = 0;
  logic [4:0] pkt_ackid = 0;
  logic tx_req, pkt_accept, err_stop, retry_stop, err_enter, retry_enter;
  logic [1:0] tx_kind;
  logic [4:0] tx_ackid, next_ackid;

  always #10 clk = ~clk;

  rx_link_recovery #(.AW(5)) u0 (
    .clk(clk), .rst_n(rst_n), .sym_vld(sym_vld), .sym_ok(sym_ok), .sym_kind(sym_kind),
    .pkt_end(pkt_end), .pkt_crc_ok(pkt_crc_ok), .pkt_ackid(pkt_ackid), .buf_free(buf_free),
    .tx_req(tx_req), .tx_kind(tx_kind), .tx_ackid(tx_ackid), .pkt_accept(pkt_accept),
    .next_ackid(next_ackid), .err_stop(err_stop), .retry_stop(retry_stop),
    .err_enter(err_enter), .retry_enter(retry_enter)
  );

  int total = 0, fails = 0;
  bit done = 0, cmp_en = 0;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: 0 running, 1 error-stopped, 2 retry-stopped
  int mst = 0, mexp = 0, m_tx = 0, m_kind = 0, m_ack = 0, m_acc = 0, m_ep = 0, m_rp = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      mst = 0; mexp = 0; m_tx = 0; m_acc = 0; m_ep = 0; m_rp = 0;
    end else begin
      m_tx = 0; m_acc = 0; m_ep = 0; m_rp = 0;
      if (mst == 0) begin
        if ((sym_vld && !sym_ok) || (pkt_end && (!pkt_crc_ok || pkt_ackid != mexp))) begin
          mst = 1; m_tx = 1; m_kind = 0; m_ack = mexp; m_ep = 1;
        end else if (pkt_end && !buf_free) begin
          mst = 2; m_tx = 1; m_kind = 1; m_ack = mexp; m_rp = 1;
        end else if (pkt_end) begin
          m_acc = 1; mexp = (mexp + 1) % 32;
        end
      end else if (mst == 1) begin
        if (sym_vld && sym_ok && sym_kind == 2'b01) begin
          mst = 0; m_tx = 1; m_kind = 2; m_ack = mexp;
        end
      end else begin
        if (sym_vld && sym_ok && sym_kind == 2'b10) mst = 0;
      end
    end
  end

  always @(negedge clk) if (cmp_en) begin
    chk("R2 pkt_accept", pkt_accept, m_acc);
    chk("R2 next_ackid", next_ackid, mexp);
    chk("R3 err_stop", err_stop, mst == 1);
    chk("R6 retry_stop", retry_stop, mst == 2);
    chk("R3 err_enter", err_enter, m_ep);
    chk("R6 retry_enter", retry_enter, m_rp);
    chk("R5 tx_req", tx_req, m_tx);
    if (m_tx != 0) begin
      chk("R5 tx_kind", tx_kind, m_kind);
      chk("R5 tx_ackid", tx_ackid, m_ack);
    end
  end

  task automatic step();
    @(posedge clk); @(negedge clk);
    sym_vld = 0; pkt_end = 0;
  endtask

  task automatic pkt(input int id, input bit crc);
    pkt_end = 1; pkt_ackid = 5'(id); pkt_crc_ok = crc; step();
  endtask

  task automatic sym(input int kind, input bit ok);
    sym_vld = 1; sym_kind = 2'(kind); sym_ok = ok; step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cmp_en = 1;
    @(negedge clk);
    chk("R1 err_stop", err_stop, 0);
    chk("R1 retry_stop", retry_stop, 0);
    chk("R1 next_ackid", next_ackid, 0);
    chk("R1 tx_req", tx_req, 0);

    for (int i = 0; i < 33; i++) pkt(i % 32, 1);
    chk("R2 wrap", next_ackid, 1);

    pkt(1, 0);
    chk("R3 crc err", err_stop, 1);
    chk("R3 pna kind", tx_kind, 0);
    chk("R3 pna id", tx_ackid, 1);
    pkt(1, 1);
    chk("R4 drop", pkt_accept, 0);
    chk("R4 id hold", next_ackid, 1);
    sym(2, 1);
    chk("R9 rfr in err", err_stop, 1);
    sym(1, 0);
    chk("R5 bad lreq", err_stop, 1);
    sym(1, 1);
    chk("R5 exit", err_stop, 0);
    chk("R5 lresp", tx_kind, 2);
    chk("R5 lresp id", tx_ackid, 1);

    pkt(7, 1);
    chk("R3 id mismatch", err_stop, 1);
    sym(1, 1);
    sym(0, 0);
    chk("R3 bad idle", err_enter, 1);
    sym(1, 1);
    pkt(1, 1);
    chk("R2 after err", next_ackid, 2);

    buf_free = 0;
    pkt(2, 1);
    chk("R6 retry", retry_stop, 1);
    chk("R6 pr kind", tx_kind, 1);
    chk("R6 pr id", tx_ackid, 2);
    sym(1, 1);
    chk("R7 lreq ignored", retry_stop, 1);
    sym(3, 0);
    chk("R7 bad sym ignored", err_stop, 0);
    buf_free = 1;
    pkt(2, 1);
    chk("R7 pkt dropped", pkt_accept, 0);
    sym(2, 1);
    chk("R7 exit", retry_stop, 0);
    chk("R7 no tx", tx_req, 0);
    pkt(2, 1);
    chk("R7 accepts", pkt_accept, 1);

    buf_free = 0;
    pkt(3, 0);
    chk("R8 err wins", err_stop, 1);
    chk("R8 not retry", retry_stop, 0);
    buf_free = 1;
    sym(1, 1);

    sym(1, 1);
    chk("R9 lreq run", tx_req, 0);
    sym(2, 1);
    chk("R9 rfr run", tx_req, 0);
    sym(0, 1);
    sym(3, 1);
    chk("R9 idle run", err_stop, 0);
    pkt(3, 1);
    chk("R9 still runs", next_ackid, 4);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule